// File: doc/BRIEF.md
# Two-Port Shared Memory with Address-Collision Arbitration

This block is the front end and storage for a memory shared by two independent requesters, called left and right. Each side presents a select, a write enable, an address and write data on every clock. When both sides are selected on the same word, the block grants one side. It pulls the other side's active-low busy flag low and suppresses that side's read and write until the contested word is free. Accesses to different words go ahead on both sides in the same cycle.

The winner is whichever side was on the contested word first. That covers two cases. A side whose select was already active on the address beats a side that selects later. A side whose address was already on the word beats a side whose address moves onto it later. When both arrive in the same cycle, left wins. The held side is released in the same cycle the winner drops its select or moves its address away, and its held operation then completes.

For wider data paths, several copies can run side by side. One copy arbitrates as master, and the others run in slave mode. In slave mode the internal arbiter is off and the busy outputs stay high. Busy inputs coming from the master gate the local writes. A write is accepted only when the busy input is high in the current cycle and in the preceding `SETTLE_CYC` cycles.

Top module: `dpa_collision_arbiter`

## Requirements
- R1: In master mode, when the two sides are not both selected on the same address, both busy outputs are high. Every selected access completes: a write is stored, and a read returns the stored word on `*_rdata` one cycle later.
- R2: In master mode, when both sides are selected with equal addresses, exactly one busy output is low. A busy output is never low without such a match.
- R3: With equal addresses, the side whose select was asserted in an earlier cycle wins, and the later-selected side gets busy low.
- R4: With both selects already active, the side whose address was on the word in an earlier cycle wins, and the side whose address moves onto it gets busy low.
- R5: When both sides become selected on the same word in the same cycle, left wins and right gets busy low.
- R6: While a side's busy output is low, its write leaves the array unchanged and its read leaves its `*_rdata` unchanged.
- R7: A loser's busy stays low while both selects and both addresses are held. It goes high in the cycle the winner deasserts its select or changes its address, and the held operation then completes.
- R8: In slave mode (`slave_mode`=1), both busy outputs are held high and no arbitration takes place, even on equal addresses.
- R9: In slave mode, a write on a side is stored only when that side's `*_busy_in_n` is high in the current cycle and in the `SETTLE_CYC` preceding cycles (default 1). The settle history resets to low. A write held across a release is stored `SETTLE_CYC` cycles after the release.
- R10: In slave mode, reads proceed whatever the busy inputs are.
- R11: In slave mode, if both sides are allowed to write the same address in one cycle, the left data is stored.
- R12: During and right after reset, both busy outputs are high and both read data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slave_mode | input | 1 | 1: slave (busy taken from inputs); 0: master (internal arbiter) |
| l_cs | input | 1 | Left select, active high |
| l_we | input | 1 | Left write enable (1 write, 0 read) |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left registered read data |
| l_busy_in_n | input | 1 | Left busy from a master, active low (slave mode) |
| l_busy_out_n | output | 1 | Left busy flag, active low (master mode) |
| r_cs | input | 1 | Right select, active high |
| r_we | input | 1 | Right write enable |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right registered read data |
| r_busy_in_n | input | 1 | Right busy from a master, active low (slave mode) |
| r_busy_out_n | output | 1 | Right busy flag, active low (master mode) |

## Verification
The assertions assume that every input is synchronous to `clk` and holds steady for a whole cycle. They also assume that `slave_mode` changes only while both selects are low, because the ownership history is only meaningful within one mode. The stimulus drives all inputs on the falling edge and switches modes only during idle cycles. It reads back only words it has written earlier, so the stored contents are always known. It also holds a losing side's request stable across the busy window, as a real requester would, so the hold-until-done properties are exercised.

// File: rtl/dpa_pkg.sv
package dpa_pkg;

   localparam int NPORTS = 2;
   localparam int PL     = 0;
   localparam int PR     = 1;

   typedef enum logic [1:0] {
      OWN_NONE  = 2'd0,
      OWN_LEFT  = 2'd1,
      OWN_RIGHT = 2'd2
   } owner_e;

endpackage

// File: rtl/dpa_port_track.sv
module dpa_port_track #(
   parameter int ADDR_W     = 11,
   parameter int SETTLE_CYC = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs,
   input  logic [ADDR_W-1:0] addr,
   input  logic              busy_in_n,
   output logic              est,
   output logic              settled
);

   logic              prev_cs;
   logic [ADDR_W-1:0] prev_addr;

   // history of where this side was last cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_cs   <= 1'b0;
         prev_addr <= '0;
      end else begin
         prev_cs   <= cs;
         prev_addr <= addr;
      end
   end

   assign est = cs && prev_cs && (addr == prev_addr);

   // settle window for busy from a master
   generate
      if (SETTLE_CYC == 0) begin : g_settle_none
         assign settled = busy_in_n;
      end else if (SETTLE_CYC == 1) begin : g_settle_one
         logic hist_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hist_q <= 1'b0;
            else        hist_q <= busy_in_n;
         end
         assign settled = busy_in_n && hist_q;
      end else begin : g_settle_many
         logic [SETTLE_CYC-1:0] hist_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hist_q <= '0;
            else        hist_q <= {hist_q[SETTLE_CYC-2:0], busy_in_n};
         end
         assign settled = busy_in_n && (&hist_q);
      end
   endgenerate

endmodule

// File: rtl/dpa_arbiter.sv
module dpa_arbiter
   import dpa_pkg::*;
#(
   parameter int ADDR_W = 11
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          enable,
   input  logic [NPORTS-1:0]             cs,
   input  logic [NPORTS-1:0][ADDR_W-1:0] addr,
   input  logic [NPORTS-1:0]             est,
   output logic [NPORTS-1:0]             busy_n
);

   logic   hit;
   owner_e winner;
   owner_e owner_q;

   assign hit = enable && cs[PL] && cs[PR] && (addr[PL] == addr[PR]);

   always_comb begin
      if (!hit)                            winner = OWN_NONE;
      else if (est[PL] && !est[PR])        winner = OWN_LEFT;
      else if (est[PR] && !est[PL])        winner = OWN_RIGHT;
      else if (est[PL] && est[PR] && owner_q == OWN_RIGHT)
                                           winner = OWN_RIGHT;
      else                                 winner = OWN_LEFT;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) owner_q <= OWN_NONE;
      else        owner_q <= winner;
   end

   assign busy_n[PL] = (winner != OWN_RIGHT);
   assign busy_n[PR] = (winner != OWN_LEFT);

   AST_OWNER_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && est[PL] && est[PR] && owner_q != OWN_NONE) |-> (winner == owner_q)); // R7

endmodule

// File: rtl/dpa_store.sv
module dpa_store
   import dpa_pkg::*;
#(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NPORTS-1:0]             wr_en,
   input  logic [NPORTS-1:0]             rd_en,
   input  logic [NPORTS-1:0][ADDR_W-1:0] addr,
   input  logic [NPORTS-1:0][DATA_W-1:0] wdata,
   output logic [NPORTS-1:0][DATA_W-1:0] rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   // right first so a same-word left write lands last
   always_ff @(posedge clk) begin
      if (wr_en[PR]) mem[addr[PR]] <= wdata[PR];
      if (wr_en[PL]) mem[addr[PL]] <= wdata[PL];
   end

   generate
      for (genvar p = 0; p < NPORTS; p++) begin : g_rd
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        rdata[p] <= '0;
            else if (rd_en[p]) rdata[p] <= mem[addr[p]];
         end
      end
   endgenerate

endmodule

// File: rtl/dpa_collision_arbiter.sv
module dpa_collision_arbiter
   import dpa_pkg::*;
#(
   parameter int ADDR_W     = 11,
   parameter int DATA_W     = 16,
   parameter int SETTLE_CYC = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slave_mode,
   input  logic              l_cs,
   input  logic              l_we,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [DATA_W-1:0] l_wdata,
   output logic [DATA_W-1:0] l_rdata,
   input  logic              l_busy_in_n,
   output logic              l_busy_out_n,
   input  logic              r_cs,
   input  logic              r_we,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic [DATA_W-1:0] r_wdata,
   output logic [DATA_W-1:0] r_rdata,
   input  logic              r_busy_in_n,
   output logic              r_busy_out_n
);

   generate
      if (ADDR_W < 2 || ADDR_W > 13) begin : g_bad_addr_w
         $error("dpa_collision_arbiter: ADDR_W must lie in 2..13");
      end
      if (DATA_W < 1) begin : g_bad_data_w
         $error("dpa_collision_arbiter: DATA_W must be at least 1");
      end
      if (SETTLE_CYC < 0 || SETTLE_CYC > 4) begin : g_bad_settle
         $error("dpa_collision_arbiter: SETTLE_CYC must lie in 0..4");
      end
   endgenerate

   logic [NPORTS-1:0]             cs_v, we_v, bin_v, est_v, settled_v;
   logic [NPORTS-1:0]             arb_bn, wr_v, rd_v;
   logic [NPORTS-1:0][ADDR_W-1:0] addr_v;
   logic [NPORTS-1:0][DATA_W-1:0] wd_v, rdo_v;

   assign cs_v       = {r_cs, l_cs};
   assign we_v       = {r_we, l_we};
   assign bin_v      = {r_busy_in_n, l_busy_in_n};
   assign addr_v[PL] = l_addr;
   assign addr_v[PR] = r_addr;
   assign wd_v[PL]   = l_wdata;
   assign wd_v[PR]   = r_wdata;

   generate
      for (genvar p = 0; p < NPORTS; p++) begin : g_port
         dpa_port_track #(
            .ADDR_W     (ADDR_W),
            .SETTLE_CYC (SETTLE_CYC)
         ) u_track (
            .clk       (clk),
            .rst_n     (rst_n),
            .cs        (cs_v[p]),
            .addr      (addr_v[p]),
            .busy_in_n (bin_v[p]),
            .est       (est_v[p]),
            .settled   (settled_v[p])
         );

         assign rd_v[p] = cs_v[p] && !we_v[p] && arb_bn[p];
         assign wr_v[p] = cs_v[p] && we_v[p] &&
                          (slave_mode ? settled_v[p] : arb_bn[p]);

         AST_BUSY_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
            !arb_bn[p] |-> (&cs_v && addr_v[PL] == addr_v[PR])); // R2

         AST_LOSER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            (!slave_mode && $past(!slave_mode) && $past(!arb_bn[p]) &&
             &cs_v && $past(&cs_v) && $stable(addr_v)) |-> !arb_bn[p]); // R7

         AST_LOSER_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
            (!slave_mode && $past(!arb_bn[p]) &&
             !(&cs_v && addr_v[PL] == addr_v[PR])) |-> arb_bn[p]); // R7

         if (SETTLE_CYC >= 1) begin : g_settle_chk
            AST_SLAVE_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
               (slave_mode && wr_v[p]) |-> (bin_v[p] && $past(bin_v[p]))); // R9
         end
      end
   endgenerate

   dpa_arbiter #(
      .ADDR_W (ADDR_W)
   ) u_arb (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (!slave_mode),
      .cs     (cs_v),
      .addr   (addr_v),
      .est    (est_v),
      .busy_n (arb_bn)
   );

   dpa_store #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_v),
      .rd_en (rd_v),
      .addr  (addr_v),
      .wdata (wd_v),
      .rdata (rdo_v)
   );

   assign l_rdata      = rdo_v[PL];
   assign r_rdata      = rdo_v[PR];
   assign l_busy_out_n = arb_bn[PL];
   assign r_busy_out_n = arb_bn[PR];

   AST_ONE_LOSER: assert property (@(posedge clk) disable iff (!rst_n)
      (l_busy_out_n || r_busy_out_n)); // R2

   AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      slave_mode |-> (l_busy_out_n && r_busy_out_n)); // R8

   AST_SINGLE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
      (!slave_mode && wr_v[PL] && wr_v[PR]) |-> (addr_v[PL] != addr_v[PR])); // R6

endmodule

// File: tb/dpa_collision_arbiter_bench.sv
`timescale 1ns/1ps
module dpa_collision_arbiter_bench;

   localparam int AW = 11;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          slave = 1'b0;
   logic          l_cs = 0, l_we = 0, l_bin = 1;
   logic [AW-1:0] l_addr = '0;
   logic [DW-1:0] l_wdata = '0;
   logic          r_cs = 0, r_we = 0, r_bin = 1;
   logic [AW-1:0] r_addr = '0;
   logic [DW-1:0] r_wdata = '0;
   logic [DW-1:0] l_rdata, r_rdata;
   logic          l_bout, r_bout;

   always #10 clk = ~clk;

   dpa_collision_arbiter #(.ADDR_W(AW), .DATA_W(DW), .SETTLE_CYC(1)) u_dpa_collision_arbiter (
      .clk(clk), .rst_n(rst_n), .slave_mode(slave),
      .l_cs(l_cs), .l_we(l_we), .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
      .l_busy_in_n(l_bin), .l_busy_out_n(l_bout),
      .r_cs(r_cs), .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata),
      .r_busy_in_n(r_bin), .r_busy_out_n(r_bout)
   );

   int    checks = 0;
   int    errors = 0;
   string req = "R12";

   // reference model state
   logic [DW-1:0] mem_m [int];
   int            cyc = 0, arr_l = 0, arr_r = 0;
   logic          pcs_l = 0, pcs_r = 0, pbin_l = 0, pbin_r = 0;
   logic [AW-1:0] pal = '0, par = '0;
   logic [DW-1:0] erl = '0, err = '0;
   logic          kl = 1, kr = 1;

   task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic drv_l(logic cs, logic we, int a, int d);
      l_cs = cs; l_we = we; l_addr = AW'(a); l_wdata = DW'(d);
   endtask

   task automatic drv_r(logic cs, logic we, int a, int d);
      r_cs = cs; r_we = we; r_addr = AW'(a); r_wdata = DW'(d);
   endtask

   // one clock: busy checked before the edge, read data after it
   task automatic cycle();
      logic conf, lwin, ebl, ebr, okl, okr;
      #2;
      cyc++;
      if (!(l_cs && pcs_l && l_addr == pal)) arr_l = cyc;
      if (!(r_cs && pcs_r && r_addr == par)) arr_r = cyc;
      conf = !slave && l_cs && r_cs && (l_addr == r_addr);
      lwin = (arr_l <= arr_r);
      ebl  = !(conf && !lwin);
      ebr  = !(conf && lwin);
      chk("left busy", 32'(l_bout), 32'(ebl));
      chk("right busy", 32'(r_bout), 32'(ebr));
      okl = slave ? (l_bin && pbin_l) : ebl;
      okr = slave ? (r_bin && pbin_r) : ebr;
      @(posedge clk);
      if (l_cs && !l_we && ebl) begin
         kl = mem_m.exists(int'(l_addr));
         if (kl) erl = mem_m[int'(l_addr)];
      end
      if (r_cs && !r_we && ebr) begin
         kr = mem_m.exists(int'(r_addr));
         if (kr) err = mem_m[int'(r_addr)];
      end
      if (r_cs && r_we && okr) mem_m[int'(r_addr)] = r_wdata;
      if (l_cs && l_we && okl) mem_m[int'(l_addr)] = l_wdata;
      pcs_l = l_cs; pal = l_addr; pbin_l = l_bin;
      pcs_r = r_cs; par = r_addr; pbin_r = r_bin;
      @(negedge clk);
      if (kl) chk("left rdata", 32'(l_rdata), 32'(erl));
      if (kr) chk("right rdata", 32'(r_rdata), 32'(err));
   endtask

   task automatic idle(int n);
      drv_l(0, 0, 0, 0);
      drv_r(0, 0, 0, 0);
      for (int i = 0; i < n; i++) cycle();
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog run did not complete actual timeout expected end");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R12: reset state
      chk("left busy in reset", 32'(l_bout), 32'd1);
      chk("right busy in reset", 32'(r_bout), 32'd1);
      chk("left rdata in reset", 32'(l_rdata), 32'd0);
      chk("right rdata in reset", 32'(r_rdata), 32'd0);
      rst_n = 1'b1;
      idle(1);

      // R1: independent accesses on different words
      req = "R1";
      drv_l(1, 1, 5, 'h1111); drv_r(1, 1, 9, 'h2222); cycle();
      drv_l(1, 0, 9, 0);      drv_r(1, 0, 5, 0);      cycle();
      drv_l(1, 0, 5, 0);      drv_r(1, 1, 6, 'h3333); cycle();
      idle(1);

      // R3: left selects first, right joins later and is held (R6, R7)
      req = "R3";
      drv_l(1, 1, 20, 'haaaa); cycle();
      drv_l(1, 0, 20, 0); cycle();
      drv_r(1, 1, 20, 'hbbbb); cycle();
      req = "R6"; cycle(); cycle();
      req = "R7"; drv_l(0, 0, 0, 0); cycle();
      drv_r(0, 0, 0, 0); drv_l(1, 0, 20, 0); cycle();
      idle(1);

      // R3: right selects first, left joins and its read is blocked
      req = "R3";
      drv_r(1, 1, 30, 'h3030); cycle();
      drv_r(1, 0, 30, 0); cycle();
      drv_l(1, 0, 30, 0); cycle();
      req = "R6"; drv_l(1, 1, 30, 'hdead); cycle(); cycle();
      req = "R7"; drv_r(0, 0, 0, 0); cycle();
      drv_l(0, 0, 0, 0); drv_r(1, 0, 30, 0); cycle();
      idle(1);

      // R4: both selected, right address moves onto left's word
      req = "R4";
      drv_l(1, 1, 40, 'h4040); drv_r(1, 1, 41, 'h4141); cycle();
      drv_l(1, 0, 40, 0); drv_r(1, 0, 41, 0); cycle();
      drv_r(1, 0, 40, 0); cycle();
      req = "R6"; cycle();
      req = "R7"; drv_l(1, 0, 41, 0); cycle(); cycle();
      idle(1);

      // R4: left address moves onto right's word with a write
      req = "R4";
      drv_l(1, 0, 41, 0); drv_r(1, 0, 40, 0); cycle();
      drv_l(1, 1, 40, 'hbad0); cycle();
      req = "R6"; cycle();
      req = "R7"; drv_r(1, 0, 5, 0); cycle();
      drv_l(1, 0, 40, 0); drv_r(0, 0, 0, 0); cycle();
      idle(1);

      // R5: both arrive in the same cycle
      req = "R5";
      drv_l(1, 1, 60, 'h6001); drv_r(1, 1, 60, 'h6002); cycle(); cycle();
      req = "R7"; drv_l(0, 0, 0, 0); cycle();
      drv_r(1, 0, 60, 0); cycle();
      req = "R5";
      drv_l(1, 0, 60, 0); drv_r(1, 0, 60, 0);
      idle(0); cycle();
      drv_l(1, 0, 60, 0); drv_r(1, 0, 60, 0); cycle(); cycle();
      idle(1);

      // R2: a run of mixed patterns, busy compared every cycle
      req = "R2";
      for (int i = 0; i < 40; i++) begin
         drv_l(1, (i % 3) == 0, 100 + (i % 4), 'h7000 + i);
         drv_r((i % 5) != 4, (i % 2) == 0, 100 + ((i / 2) % 4), 'h8000 + i);
         cycle();
      end
      idle(1);

      // R8: slave mode, equal addresses produce no busy
      slave = 1'b1;
      idle(1);
      req = "R8";
      drv_l(1, 0, 100, 0); drv_r(1, 0, 100, 0); cycle(); cycle();
      idle(1);

      // R9: busy input low blocks write; settle then write
      req = "R9";
      l_bin = 1'b0;
      drv_l(1, 1, 70, 'h7777); cycle(); cycle();
      l_bin = 1'b1; cycle();
      cycle();
      drv_l(1, 0, 70, 0); cycle();
      l_bin = 1'b0; drv_l(1, 1, 70, 'h1234); cycle();
      l_bin = 1'b1; drv_l(0, 0, 0, 0); cycle();
      drv_l(1, 0, 70, 0); cycle();
      idle(1);

      // R10: reads ignore busy inputs in slave mode
      req = "R10";
      r_bin = 1'b0; drv_r(1, 0, 70, 0); cycle();
      drv_r(1, 0, 20, 0); cycle();
      r_bin = 1'b1;
      idle(2);

      // R11: same-word writes from both sides
      req = "R11";
      drv_l(1, 1, 80, 'habcd); drv_r(1, 1, 80, 'h5555); cycle();
      drv_l(1, 0, 80, 0); drv_r(1, 0, 80, 0); cycle();
      idle(1);

      slave = 1'b0;
      idle(1);
      req = "R1";
      drv_l(1, 0, 80, 0); drv_r(1, 0, 70, 0); cycle();
      idle(1);

      finish_run();
   end

endmodule